// File: doc/BRIEF.md
# Segment Limit and Type Checker

The block sits next to address generation and judges each memory reference against the attributes cached for the segment register that reference uses. It builds the effective limit from a 20-bit raw limit and a granularity bit. It works out the last byte the access touches, for an access of one, two or four bytes. It then tests that byte range against either the normal range or the inverted range of an expand-down data segment. Beside the limit test it checks the access kind against the segment type: data read, data write or instruction fetch. The verdict comes out one cycle after the strobe: a pass pulse, or a fault pulse with a cause code.

A second, independent port judges descriptor types when a selector is loaded into a named segment register. The code register needs an executable descriptor. The stack register needs a writable data descriptor. The four data registers refuse code that cannot be read. A descriptor marked absent is refused. Fetching descriptors from tables and comparing privilege are left to neighbouring logic.

Top module: `seg_guard`

## Requirements
- R1: One cycle after a reference strobe, exactly one of ref_pass_o and ref_fault_o is high. In a cycle that follows no strobe, both are low. Under reset every output is zero.
- R2: With gran_i clear, the effective limit is the raw limit in bytes. With gran_i set, it is the raw limit shifted left 12 bits with ones filled into bits 11:0.
- R3: For a normal segment, a reference faults with the limit cause when its last byte, offset + bytes - 1, lies above the effective limit. The sum is formed in 33 bits, so a wrap past 0xFFFFFFFF faults. The size code means 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R4: For an expand-down data segment (xdown_i = 1, exec_i = 0, read or write), a reference passes only when the offset is above the effective limit and the last byte is at most the upper bound. The upper bound is 0xFFFF with big_i clear and 0xFFFFFFFF with big_i set. A raw limit of 0 therefore allows offsets from 1 up to the upper bound.
- R5: The kind code means 0 = read, 1 = write, 2 or 3 = fetch. A write to an executable segment faults with the type cause. So does a write to a data segment whose rw_i is clear, and so does a read of an executable segment whose rw_i is clear. Reads of data segments are always type-legal.
- R6: A fetch is never refused for type. It is checked only against the normal limit range, and xdown_i is ignored for it.
- R7: The cause code means 1 = limit, 2 = type, 3 = not present, and it is 0 on pass. A type violation outranks an absent descriptor (pres_i = 0), and an absent descriptor outranks a limit violation.
- R8: On a load, the register code means 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS, 5 = GS. CS refuses a non-executable descriptor. SS refuses anything other than writable data. ES, DS, FS and GS refuse executable descriptors whose rw_i is clear. Codes 6 and 7 are refused. Every refusal gives cause 2.
- R9: A load that passes the type rules but has ld_pres_i clear faults with cause 3.
- R10: The load result appears one cycle after ld_valid_i, with the same one-hot pass/fault pulse as R1. It is independent of any reference checked in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_valid_i | input | 1 | Reference strobe |
| lim_raw_i | input | 20 | Raw descriptor limit |
| gran_i | input | 1 | Limit in 4 KiB units |
| xdown_i | input | 1 | Expand-down data segment |
| big_i | input | 1 | Expand-down upper bound select |
| exec_i | input | 1 | Segment is executable |
| rw_i | input | 1 | Readable (code) or writable (data) |
| pres_i | input | 1 | Descriptor present |
| off_i | input | 32 | Reference offset |
| size_i | input | 2 | Access size code |
| kind_i | input | 2 | Access kind code |
| ref_pass_o | output | 1 | Reference accepted |
| ref_fault_o | output | 1 | Reference faulted |
| ref_cause_o | output | 2 | Reference fault cause |
| ld_valid_i | input | 1 | Segment load strobe |
| ld_sreg_i | input | 3 | Target segment register |
| ld_exec_i | input | 1 | Loaded descriptor executable |
| ld_rw_i | input | 1 | Loaded descriptor readable/writable |
| ld_pres_i | input | 1 | Loaded descriptor present |
| ld_pass_o | output | 1 | Load accepted |
| ld_fault_o | output | 1 | Load faulted |
| ld_cause_o | output | 2 | Load fault cause |

## Verification
The bench builds the block with its default parameters: a 32-bit offset, a 20-bit raw limit and a 16-bit small expand-down bound. With these, every edge case in the requirements can be reached exactly. That covers the 0xFFF and 0xFFFFFFFF expanded limits, the carry out of the 33-bit last-byte sum, and both expand-down bounds at 0xFFFF and 0xFFFFFFFF. Each access size is placed one byte inside and one byte outside the limit. The cause priorities are tested with inputs that violate two rules at once.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_LIMIT  = 2'd1,
    CAUSE_TYPE   = 2'd2,
    CAUSE_ABSENT = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_WRITE  = 2'd1,
    ACC_FETCH  = 2'd2,
    ACC_FETCHX = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    SR_ES = 3'd0,
    SR_CS = 3'd1,
    SR_SS = 3'd2,
    SR_DS = 3'd3,
    SR_FS = 3'd4,
    SR_GS = 3'd5,
    SR_R6 = 3'd6,
    SR_R7 = 3'd7
  } sreg_e;

  typedef struct packed {
    logic viol;
    cause_e cause;
  } verdict_t;
endpackage

// File: rtl/seg_lim_unit.sv
module seg_lim_unit #(
  parameter int OFF_W   = 32,
  parameter int LIM_W   = 20,
  parameter int SMALL_W = 16
) (
  input  logic [LIM_W-1:0] lim_raw_i,
  input  logic             gran_i,
  input  logic             xdown_i,
  input  logic             big_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic             viol_o
);
  localparam int SH = OFF_W - LIM_W;

  logic [OFF_W-1:0] eff_lim;
  logic [OFF_W-1:0] upper;
  logic [1:0]       span_m1;
  logic [OFF_W:0]   last_b;
  logic             norm_viol;
  logic             xd_viol;

  always_comb begin
    if (gran_i) eff_lim = {lim_raw_i, {SH{1'b1}}};
    else        eff_lim = {{SH{1'b0}}, lim_raw_i};
  end

  always_comb begin
    unique case (size_i)
      2'd0:    span_m1 = 2'd0;
      2'd1:    span_m1 = 2'd1;
      default: span_m1 = 2'd3;
    endcase
  end

  // 33-bit sum: carry out counts as beyond any limit
  assign last_b = {1'b0, off_i} + {{(OFF_W-1){1'b0}}, span_m1};

  assign upper = big_i ? {OFF_W{1'b1}} : {{(OFF_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};

  assign norm_viol = last_b > {1'b0, eff_lim};
  assign xd_viol   = (off_i <= eff_lim) || (last_b > {1'b0, upper});
  assign viol_o    = xdown_i ? xd_viol : norm_viol;
endmodule

// File: rtl/seg_acc_type.sv
module seg_acc_type
  import seg_guard_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic       exec_i,
  input  logic       rw_i,
  output logic       viol_o,
  output logic       fetch_o
);
  always_comb begin
    fetch_o = 1'b0;
    unique case (acc_e'(kind_i))
      ACC_READ:  viol_o = exec_i & ~rw_i;
      ACC_WRITE: viol_o = exec_i | ~rw_i;
      default: begin
        viol_o  = 1'b0;
        fetch_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/seg_load_type.sv
module seg_load_type
  import seg_guard_pkg::*;
(
  input  logic [2:0] sreg_i,
  input  logic       exec_i,
  input  logic       rw_i,
  input  logic       pres_i,
  output verdict_t   verdict_o
);
  logic tviol;

  always_comb begin
    unique case (sreg_e'(sreg_i))
      SR_CS:                      tviol = ~exec_i;
      SR_SS:                      tviol = exec_i | ~rw_i;
      SR_ES, SR_DS, SR_FS, SR_GS: tviol = exec_i & ~rw_i;
      default:                    tviol = 1'b1;
    endcase
  end

  always_comb begin
    if (tviol)        verdict_o = '{viol: 1'b1, cause: CAUSE_TYPE};
    else if (!pres_i) verdict_o = '{viol: 1'b1, cause: CAUSE_ABSENT};
    else              verdict_o = '{viol: 1'b0, cause: CAUSE_NONE};
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int LIM_W   = 20,
  parameter int SMALL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_valid_i,
  input  logic [LIM_W-1:0] lim_raw_i,
  input  logic             gran_i,
  input  logic             xdown_i,
  input  logic             big_i,
  input  logic             exec_i,
  input  logic             rw_i,
  input  logic             pres_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       kind_i,
  output logic             ref_pass_o,
  output logic             ref_fault_o,
  output logic [1:0]       ref_cause_o,
  input  logic             ld_valid_i,
  input  logic [2:0]       ld_sreg_i,
  input  logic             ld_exec_i,
  input  logic             ld_rw_i,
  input  logic             ld_pres_i,
  output logic             ld_pass_o,
  output logic             ld_fault_o,
  output logic [1:0]       ld_cause_o
);
  logic     lim_viol, type_viol, is_fetch, xd_eff;
  verdict_t ref_v, ld_v;

  // expand-down only for data reads/writes
  assign xd_eff = xdown_i & ~exec_i & ~is_fetch;

  seg_acc_type u_acc (
    .kind_i  (kind_i),
    .exec_i  (exec_i),
    .rw_i    (rw_i),
    .viol_o  (type_viol),
    .fetch_o (is_fetch)
  );

  seg_lim_unit #(.OFF_W(OFF_W), .LIM_W(LIM_W), .SMALL_W(SMALL_W)) u_lim (
    .lim_raw_i (lim_raw_i),
    .gran_i    (gran_i),
    .xdown_i   (xd_eff),
    .big_i     (big_i),
    .off_i     (off_i),
    .size_i    (size_i),
    .viol_o    (lim_viol)
  );

  seg_load_type u_ld (
    .sreg_i    (ld_sreg_i),
    .exec_i    (ld_exec_i),
    .rw_i      (ld_rw_i),
    .pres_i    (ld_pres_i),
    .verdict_o (ld_v)
  );

  always_comb begin
    if (type_viol)     ref_v = '{viol: 1'b1, cause: CAUSE_TYPE};
    else if (!pres_i)  ref_v = '{viol: 1'b1, cause: CAUSE_ABSENT};
    else if (lim_viol) ref_v = '{viol: 1'b1, cause: CAUSE_LIMIT};
    else               ref_v = '{viol: 1'b0, cause: CAUSE_NONE};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_pass_o  <= 1'b0;
      ref_fault_o <= 1'b0;
      ref_cause_o <= CAUSE_NONE;
    end else begin
      ref_pass_o  <= ref_valid_i & ~ref_v.viol;
      ref_fault_o <= ref_valid_i & ref_v.viol;
      ref_cause_o <= ref_valid_i ? ref_v.cause : CAUSE_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pass_o  <= 1'b0;
      ld_fault_o <= 1'b0;
      ld_cause_o <= CAUSE_NONE;
    end else begin
      ld_pass_o  <= ld_valid_i & ~ld_v.viol;
      ld_fault_o <= ld_valid_i & ld_v.viol;
      ld_cause_o <= ld_valid_i ? ld_v.cause : CAUSE_NONE;
    end
  end

  a_r1_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i |=> (ref_pass_o ^ ref_fault_o));
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> (!ref_pass_o && !ref_fault_o));
  a_r7_cause_agrees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_fault_o |-> (ref_cause_o != CAUSE_NONE));
  a_r5_write_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && kind_i == ACC_WRITE && exec_i) |=> (ref_fault_o && ref_cause_o == CAUSE_TYPE));
  a_r6_fetch_no_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && kind_i[1]) |=> (ref_cause_o != CAUSE_TYPE));
  a_r8_cs_needs_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_sreg_i == SR_CS && !ld_exec_i) |=> (ld_fault_o && ld_cause_o == CAUSE_TYPE));
  a_r10_ld_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> (ld_pass_o ^ ld_fault_o));
endmodule

// File: tb/tb_seg_guard.sv
module tb_seg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  // {req, raw, {gran,xd,big,exec,rw,pres}, off, size, kind, exp_cause}
  localparam logic [67:0] VEC [NV] = '{
    {4'd3, 20'h00FFF, 6'b000011, 32'h00000FFF, 2'd0, 2'd0, 2'd0}, // R3 byte at limit
    {4'd3, 20'h00FFF, 6'b000011, 32'h00001000, 2'd0, 2'd0, 2'd1}, // R3 byte past limit
    {4'd3, 20'h00FFF, 6'b000011, 32'h00000FFE, 2'd1, 2'd0, 2'd0}, // R3 word fits
    {4'd3, 20'h00FFF, 6'b000011, 32'h00000FFF, 2'd1, 2'd0, 2'd1}, // R3 word straddles
    {4'd3, 20'h00FFF, 6'b000011, 32'h00000FFC, 2'd2, 2'd1, 2'd0}, // R3 dword fits
    {4'd3, 20'h00FFF, 6'b000011, 32'h00000FFD, 2'd2, 2'd0, 2'd1}, // R3 dword straddles
    {4'd2, 20'h00000, 6'b100011, 32'h00000FFF, 2'd0, 2'd0, 2'd0}, // R2 min granular limit
    {4'd2, 20'h00000, 6'b100011, 32'h00001000, 2'd0, 2'd0, 2'd1}, // R2
    {4'd2, 20'hFFFFF, 6'b100011, 32'hFFFFFFFC, 2'd2, 2'd0, 2'd0}, // R2 full 4 GiB
    {4'd3, 20'hFFFFF, 6'b100011, 32'hFFFFFFFD, 2'd2, 2'd0, 2'd1}, // R3 wrap
    {4'd3, 20'h00FFF, 6'b000011, 32'h00000FFD, 2'd3, 2'd0, 2'd1}, // R3 size 3 = 4 bytes
    {4'd4, 20'h00FFF, 6'b010011, 32'h00000FFF, 2'd0, 2'd0, 2'd1}, // R4 at limit invalid
    {4'd4, 20'h00FFF, 6'b010011, 32'h00001000, 2'd0, 2'd1, 2'd0}, // R4 limit+1 valid
    {4'd4, 20'h00FFF, 6'b010011, 32'h0000FFFE, 2'd1, 2'd0, 2'd0}, // R4 small top
    {4'd4, 20'h00FFF, 6'b010011, 32'h0000FFFF, 2'd1, 2'd0, 2'd1}, // R4 past small top
    {4'd4, 20'h00FFF, 6'b011011, 32'h0000FFFF, 2'd1, 2'd0, 2'd0}, // R4 big
    {4'd4, 20'h00FFF, 6'b011011, 32'hFFFFFFFF, 2'd0, 2'd0, 2'd0}, // R4 big top
    {4'd4, 20'h00FFF, 6'b011011, 32'hFFFFFFFE, 2'd2, 2'd0, 2'd1}, // R4 big wrap
    {4'd4, 20'h00000, 6'b011011, 32'h00000000, 2'd0, 2'd0, 2'd1}, // R4 limit 0
    {4'd4, 20'h00000, 6'b011011, 32'h00000001, 2'd0, 2'd0, 2'd0}, // R4 limit 0
    {4'd5, 20'h00FFF, 6'b000111, 32'h00000000, 2'd0, 2'd1, 2'd2}, // R5 write code
    {4'd5, 20'h00FFF, 6'b000001, 32'h00000000, 2'd0, 2'd1, 2'd2}, // R5 write read-only
    {4'd5, 20'h00FFF, 6'b000101, 32'h00000000, 2'd0, 2'd0, 2'd2}, // R5 read exec-only
    {4'd5, 20'h00FFF, 6'b000111, 32'h00000010, 2'd1, 2'd0, 2'd0}, // R5 read readable code
    {4'd5, 20'h00FFF, 6'b000001, 32'h00000010, 2'd2, 2'd0, 2'd0}, // R5 read read-only data
    {4'd6, 20'h00FFF, 6'b000101, 32'h00000000, 2'd0, 2'd2, 2'd0}, // R6 fetch exec-only
    {4'd6, 20'h00FFF, 6'b000001, 32'h00000FFC, 2'd2, 2'd2, 2'd0}, // R6 fetch data
    {4'd6, 20'h00FFF, 6'b010011, 32'h00000000, 2'd0, 2'd3, 2'd0}, // R6 xdown ignored
    {4'd6, 20'h00FFF, 6'b000111, 32'h00001000, 2'd0, 2'd2, 2'd1}, // R6 fetch past limit
    {4'd7, 20'h00FFF, 6'b000010, 32'h00000000, 2'd0, 2'd0, 2'd3}, // R7 absent
    {4'd7, 20'h00FFF, 6'b000110, 32'h00000000, 2'd0, 2'd1, 2'd2}, // R7 type over absent
    {4'd7, 20'h00FFF, 6'b000010, 32'h00001000, 2'd0, 2'd0, 2'd3}, // R7 absent over limit
    {4'd7, 20'h00FFF, 6'b000111, 32'h00001000, 2'd0, 2'd1, 2'd2}  // R7 type over limit
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_valid = 1'b0, gran = 1'b0, xdown = 1'b0, big = 1'b0, exec_b = 1'b0, rw = 1'b0, pres = 1'b0;
  logic [19:0] lim_raw = '0;
  logic [31:0] off = '0;
  logic [1:0] size = '0, kind = '0;
  logic ref_pass, ref_fault;
  logic [1:0] ref_cause;
  logic ld_valid = 1'b0, ld_exec = 1'b0, ld_rw = 1'b0, ld_pres = 1'b0;
  logic [2:0] ld_sreg = '0;
  logic ld_pass, ld_fault;
  logic [1:0] ld_cause;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_valid), .lim_raw_i(lim_raw),
    .gran_i(gran), .xdown_i(xdown), .big_i(big), .exec_i(exec_b), .rw_i(rw),
    .pres_i(pres), .off_i(off), .size_i(size), .kind_i(kind),
    .ref_pass_o(ref_pass), .ref_fault_o(ref_fault), .ref_cause_o(ref_cause),
    .ld_valid_i(ld_valid), .ld_sreg_i(ld_sreg), .ld_exec_i(ld_exec),
    .ld_rw_i(ld_rw), .ld_pres_i(ld_pres),
    .ld_pass_o(ld_pass), .ld_fault_o(ld_fault), .ld_cause_o(ld_cause)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // {pass, fault, cause}
  function automatic logic [3:0] expect_of(input logic [1:0] c);
    return {(c == 2'd0), (c != 2'd0), c};
  endfunction

  task automatic run_ref(input logic [67:0] v);
    @(negedge clk);
    {lim_raw, gran, xdown, big, exec_b, rw, pres, off, size, kind} = v[63:2];
    ref_valid = 1'b1;
    @(posedge clk); #1;
    chk($sformatf("R%0d vec off=%h", v[67:64], v[37:6]),
        {ref_pass, ref_fault, ref_cause}, expect_of(v[1:0]));
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic run_ld(input string req, input logic [2:0] sr, input logic ex,
                        input logic w, input logic p, input logic [1:0] c);
    @(negedge clk);
    ld_sreg = sr; ld_exec = ex; ld_rw = w; ld_pres = p; ld_valid = 1'b1;
    @(posedge clk); #1;
    chk(req, {ld_pass, ld_fault, ld_cause}, expect_of(c));
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset ref", {ref_pass, ref_fault, ref_cause}, 4'h0);
    chk("R1 reset ld", {ld_pass, ld_fault, ld_cause}, 4'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_ref(VEC[i]);

    // R1 no strobe, inputs that would fault
    @(negedge clk);
    exec_b = 1'b1; kind = 2'd1; pres = 1'b0; off = 32'hFFFFFFFF;
    @(posedge clk); #1;
    chk("R1 idle ref", {ref_pass, ref_fault, ref_cause}, 4'h0);
    chk("R10 idle ld", {ld_pass, ld_fault, ld_cause}, 4'h0);

    // R8 load type rules
    run_ld("R8 CS code", 3'd1, 1'b1, 1'b0, 1'b1, 2'd0);
    run_ld("R8 CS data", 3'd1, 1'b0, 1'b1, 1'b1, 2'd2);
    run_ld("R8 SS rw data", 3'd2, 1'b0, 1'b1, 1'b1, 2'd0);
    run_ld("R8 SS ro data", 3'd2, 1'b0, 1'b0, 1'b1, 2'd2);
    run_ld("R8 SS code", 3'd2, 1'b1, 1'b1, 1'b1, 2'd2);
    run_ld("R8 DS exec-only", 3'd3, 1'b1, 1'b0, 1'b1, 2'd2);
    run_ld("R8 GS readable code", 3'd5, 1'b1, 1'b1, 1'b1, 2'd0);
    run_ld("R8 ES ro data", 3'd0, 1'b0, 1'b0, 1'b1, 2'd0);
    run_ld("R8 FS exec-only", 3'd4, 1'b1, 1'b0, 1'b1, 2'd2);
    run_ld("R8 code 6", 3'd6, 1'b0, 1'b1, 1'b1, 2'd2);
    run_ld("R9 CS absent", 3'd1, 1'b1, 1'b0, 1'b0, 2'd3);
    run_ld("R9 SS type over absent", 3'd2, 1'b1, 1'b1, 1'b0, 2'd2);

    // R10 both ports in one cycle: ref faults, load passes
    @(negedge clk);
    {lim_raw, gran, xdown, big, exec_b, rw, pres} = {20'h00FFF, 6'b000011};
    off = 32'h00002000; size = 2'd0; kind = 2'd0; ref_valid = 1'b1;
    ld_sreg = 3'd3; ld_exec = 1'b0; ld_rw = 1'b1; ld_pres = 1'b1; ld_valid = 1'b1;
    @(posedge clk); #1;
    chk("R10 ref side", {ref_pass, ref_fault, ref_cause}, expect_of(2'd1));
    chk("R10 ld side", {ld_pass, ld_fault, ld_cause}, expect_of(2'd0));
    @(negedge clk);
    ref_valid = 1'b0; ld_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 pulse ends", {ref_pass, ref_fault, ld_pass, ld_fault}, 4'h0);

    finish_up();
  end
endmodule